// File: doc/BRIEF.md
# 16-bit Arithmetic and Logic Unit with Status Flags

This unit is a purely combinational datapath element. It takes two 16-bit operands and a 4-bit operation code, and it returns a 16-bit result together with four status flags: zero, carry, negative and signed overflow. It also returns a flag that marks an unassigned operation code. The unit holds no state, so the surrounding pipeline samples the result and the flags on its own clock edge.

The operation set has three groups. The arithmetic group is add, subtract and unary negate. The bitwise group is AND, OR and NOT. The shift and compare group is shift left, logical shift right, arithmetic shift right and three compares that each return a 0/1 word. The add, subtract and negate operations share one adder. Shifts come from a barrel shifter or from a plain shift operator, and a parameter chooses which one is built.

Top module: `alu16_core`

## Requirements
- R1: Code 0 (ADD) returns A+B modulo 2^16. Carry is the carry out of bit 15.
- R2: Code 1 (SUB) returns A-B, computed as A + ~B + 1. Carry is 1 exactly when no borrow occurs, which is when A >= B as unsigned numbers.
- R3: Code 2 (NEG) returns the two's complement of A (0-A). Carry is 1 only when A is 0. Overflow is 1 only when A is 0x8000.
- R4: For ADD and SUB, overflow is 1 when the two adder inputs share a sign and the result sign differs from it. For every code other than 0, 1 and 2, overflow is 0.
- R5: Code 3 returns A AND B, code 4 returns A OR B and code 5 returns NOT A.
- R6: Code 6 shifts A left and code 7 shifts A right, both filling with zeros. The shift amount is B[3:0], and B[15:4] has no effect. An amount of 0 returns A unchanged.
- R7: Code 8 shifts A right by B[3:0] and fills the vacated bits with A[15].
- R8: Code 9 (signed A<B), code 10 (signed A>B) and code 11 (A==B) return 1 when the condition is true and 0 otherwise.
- R9: Carry is 0 for codes 3 to 15.
- R10: Codes 12 to 15 return a result of 0 and raise the illegal-op output. Codes 0 to 11 keep it low.
- R11: For every code, zero is 1 exactly when the result is 0, and negative equals result bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B; the low 4 bits give the shift amount |
| op_i | input | 4 | Operation code |
| result_o | output | 16 | Result word |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Adder carry out, or no-borrow for subtract |
| neg_o | output | 1 | Result bit 15 |
| ovf_o | output | 1 | Signed overflow |
| illegal_o | output | 1 | Operation code is unassigned |

## Verification
The unit has no register on any path, so the result and all five flags are due in the same cycle that the operands and code are applied. The bench drives new inputs just after a rising clock edge and reads every output at the following falling edge. By then the combinational paths have settled and the next stimulus has not started. The sweep applies all sixteen codes to a grid of corner operands, to every B value from 0 to 31 (which exercises the ignored upper shift bits), and to pseudo-random pairs. Each output is compared against a value computed with wide integer arithmetic.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_NEG = 4'd2,
      OP_AND = 4'd3,
      OP_OR  = 4'd4,
      OP_NOT = 4'd5,
      OP_SLL = 4'd6,
      OP_SRL = 4'd7,
      OP_SRA = 4'd8,
      OP_LT  = 4'd9,
      OP_GT  = 4'd10,
      OP_EQ  = 4'd11
   } alu_op_e;

   localparam int unsigned OP_CODE_W = 4;
   localparam int unsigned OP_LAST   = 11;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
   import alu16_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int unsigned MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] x, y;
   logic             cin;
   logic             is_arith;

   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      unique case (op)
         OP_SUB: begin
            y   = ~b;
            cin = 1'b1;
         end
         OP_NEG: begin
            x   = '0;
            y   = ~a;
            cin = 1'b1;
         end
         default: ;
      endcase
   end

   assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
   assign is_arith    = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
   assign ovf         = is_arith && (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

   always_comb begin
      if (op == OP_NEG && ovf)
         a_r3_neg_ovf_only_min: assert (a == MIN_NEG)
            else $error("negate overflow on operand other than the minimum");
      if (op == OP_SUB)
         a_r2_sub_carry_is_ge: assert (cout == (a >= b))
            else $error("subtract carry disagrees with unsigned compare");
   end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int unsigned WIDTH  = 16,
   parameter bit          BARREL = 1'b1,
   localparam int unsigned SH_W  = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] data,
   input  logic [SH_W-1:0]  amt,
   input  logic             right,
   input  logic             arith,
   output logic [WIDTH-1:0] out
);
   logic fill;
   assign fill = arith & data[WIDTH-1];

   generate
      if (BARREL) begin : g_barrel
         logic [WIDTH-1:0] stg [0:SH_W];
         assign stg[0] = data;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int unsigned S = 1 << k;
            logic [WIDTH-1:0] moved;
            assign moved = right ? {{S{fill}}, stg[k][WIDTH-1:S]}
                                 : {stg[k][WIDTH-1-S:0], {S{1'b0}}};
            assign stg[k+1] = amt[k] ? moved : stg[k];
         end
         assign out = stg[SH_W];
      end else begin : g_operator
         always_comb begin
            if (!right)     out = data << amt;
            else if (arith) out = WIDTH'($signed(data) >>> amt);
            else            out = data >> amt;
         end
      end
   endgenerate

   always_comb begin
      if (amt == '0)
         a_r6_zero_amount_identity: assert (out == data)
            else $error("shift by zero altered the operand");
      if (right && arith)
         a_r7_sign_preserved: assert (out[WIDTH-1] == data[WIDTH-1])
            else $error("arithmetic right shift lost the sign");
   end
endmodule

// File: rtl/alu16_logcmp.sv
module alu16_logcmp
   import alu16_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] log_res,
   output logic [WIDTH-1:0] cmp_res
);
   logic lt, gt, eq;

   assign lt = $signed(a) < $signed(b);
   assign gt = $signed(a) > $signed(b);
   assign eq = (a == b);

   always_comb begin
      unique case (op)
         OP_AND:  log_res = a & b;
         OP_OR:   log_res = a | b;
         OP_NOT:  log_res = ~a;
         default: log_res = '0;
      endcase
      unique case (op)
         OP_LT:   cmp_res = {{(WIDTH-1){1'b0}}, lt};
         OP_GT:   cmp_res = {{(WIDTH-1){1'b0}}, gt};
         OP_EQ:   cmp_res = {{(WIDTH-1){1'b0}}, eq};
         default: cmp_res = '0;
      endcase
   end

   always_comb begin
      if ((op == OP_LT || op == OP_GT) && a == b)
         a_r8_strict_compare_equal: assert (cmp_res == '0)
            else $error("strict compare true on equal operands");
   end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
   import alu16_pkg::*;
#(
   parameter int unsigned WIDTH        = 16,
   parameter bit          BARREL_SHIFT = 1'b1
) (
   input  logic [WIDTH-1:0]     a_i,
   input  logic [WIDTH-1:0]     b_i,
   input  logic [OP_CODE_W-1:0] op_i,
   output logic [WIDTH-1:0]     result_o,
   output logic                 zero_o,
   output logic                 carry_o,
   output logic                 neg_o,
   output logic                 ovf_o,
   output logic                 illegal_o
);
   localparam int unsigned SH_W = $clog2(WIDTH);

   initial begin
      a_width_pow2: assert (WIDTH >= 4 && (WIDTH & (WIDTH - 1)) == 0)
         else $error("WIDTH must be a power of two of at least 4");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] sum, log_res, cmp_res, sh_res;
   logic             cout, add_ovf;
   logic             is_arith, is_log, is_shift, is_cmp;

   assign op        = alu_op_e'(op_i);
   assign illegal_o = (op_i > OP_CODE_W'(OP_LAST));
   assign is_arith  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
   assign is_log    = (op == OP_AND) || (op == OP_OR)  || (op == OP_NOT);
   assign is_shift  = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
   assign is_cmp    = (op == OP_LT)  || (op == OP_GT)  || (op == OP_EQ);

   alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(a_i), .b(b_i), .op(op), .sum(sum), .cout(cout), .ovf(add_ovf)
   );

   alu16_shift #(.WIDTH(WIDTH), .BARREL(BARREL_SHIFT)) u_shift (
      .data(a_i), .amt(b_i[SH_W-1:0]),
      .right(op == OP_SRL || op == OP_SRA), .arith(op == OP_SRA),
      .out(sh_res)
   );

   alu16_logcmp #(.WIDTH(WIDTH)) u_logcmp (
      .a(a_i), .b(b_i), .op(op), .log_res(log_res), .cmp_res(cmp_res)
   );

   always_comb begin
      if (is_arith)      result_o = sum;
      else if (is_log)   result_o = log_res;
      else if (is_shift) result_o = sh_res;
      else if (is_cmp)   result_o = cmp_res;
      else               result_o = '0;
   end

   assign carry_o = is_arith & cout;
   assign ovf_o   = add_ovf;
   assign zero_o  = (result_o == '0);
   assign neg_o   = result_o[WIDTH-1];

   always_comb begin
      if (illegal_o)
         a_r10_illegal_quiet: assert (result_o == '0 && zero_o && !carry_o && !ovf_o)
            else $error("illegal code produced a non-zero result or flag");
      if (ovf_o)
         a_r4_ovf_arith_only: assert (op_i <= OP_CODE_W'(2))
            else $error("overflow raised outside add, subtract or negate");
      if (carry_o)
         a_r9_carry_arith_only: assert (op_i <= OP_CODE_W'(2))
            else $error("carry raised outside add, subtract or negate");
   end
endmodule

// File: tb/sim_alu16_core.sv
module sim_alu16_core;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [15:0] a, b;
   logic [3:0]  op;
   logic [15:0] result;
   logic        zero, carry, neg, ovf, illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int unsigned lfsr = 32'h1ACE_B00C;

   alu16_core u0 (
      .a_i(a), .b_i(b), .op_i(op), .result_o(result), .zero_o(zero),
      .carry_o(carry), .neg_o(neg), .ovf_o(ovf), .illegal_o(illegal)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
                  req, what, op, a, b, act, exp);
      end
   endtask

   function automatic string res_req(input int code);
      if (code == 0) return "R1";
      if (code == 1) return "R2";
      if (code == 2) return "R3";
      if (code <= 5) return "R5";
      if (code <= 7) return "R6";
      if (code == 8) return "R7";
      if (code <= 11) return "R8";
      return "R10";
   endfunction

   task automatic apply(input logic [15:0] va, input logic [15:0] vb);
      for (int code = 0; code < 16; code++) begin
         int ua, ub, sa, sb, s, er, amt;
         int ec, ev;
         @(posedge clk);
         a = va; b = vb; op = 4'(code);
         ua = int'(va); ub = int'(vb);
         sa = int'($signed(va)); sb = int'($signed(vb));
         amt = ub % 16;
         ec = 0; ev = 0; er = 0;
         case (code)
            0: begin er = ua + ub; ec = (er >> 16) & 1; s = sa + sb;
                     ev = int'(s > 32767 || s < -32768); end
            1: begin er = ua - ub; ec = int'(ua >= ub); s = sa - sb;
                     ev = int'(s > 32767 || s < -32768); end
            2: begin er = -ua; ec = int'(ua == 0); ev = int'(ua == 32768); end
            3: er = ua & ub;
            4: er = ua | ub;
            5: er = ~ua;
            6: er = ua << amt;
            7: er = ua >> amt;
            8: er = sa >>> amt;
            9: er = int'(sa < sb);
            10: er = int'(sa > sb);
            11: er = int'(ua == ub);
            default: er = 0;
         endcase
         er = er & 32'hFFFF;
         @(negedge clk);
         chk(res_req(code), "result", int'(result), er);
         chk(code <= 2 ? res_req(code) : "R9", "carry", int'(carry), ec);
         chk(code == 2 ? "R3" : "R4", "overflow", int'(ovf), ev);
         chk("R10", "illegal", int'(illegal), int'(code >= 12));
         chk("R11", "zero", int'(zero), int'(er == 0));
         chk("R11", "negative", int'(neg), (er >> 15) & 1);
      end
   endtask

   function automatic logic [15:0] corner(input int i);
      case (i)
         0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
         3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
         6: return 16'hFFFF;  7: return 16'hFFFE;  8: return 16'h00FF;
         9: return 16'hFF00; 10: return 16'h5555; 11: return 16'hAAAA;
         12: return 16'h000F; 13: return 16'h0010; 14: return 16'h1234;
         default: return 16'hF0F0;
      endcase
   endfunction

   initial begin
      a = '0; b = '0; op = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // idle inputs: ADD of zeros gives zero result with only zero flag set (R11, R1)
      chk("R1", "idle result", int'(result), 0);
      chk("R11", "idle zero", int'(zero), 1);
      chk("R10", "idle illegal", int'(illegal), 0);
      // corner grid, all codes
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            apply(corner(i), corner(j));
      // every shift amount, upper B bits set in half the cases (R6, R7)
      for (int i = 0; i < 4; i++)
         for (int k = 0; k < 32; k++)
            apply(corner(i * 4 + 3), 16'(k) | (k >= 16 ? 16'hA5A0 : 16'h0000));
      // pseudo-random pairs
      for (int n = 0; n < 300; n++) begin
         logic [15:0] ra, rb;
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         ra = lfsr[31:16];
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         rb = lfsr[31:16];
         apply(ra, rb);
      end
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired before the sweep ended");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule